// File: doc/BRIEF.md
# Serial Configuration Register with Diagnostic Readback

This block is the serial front end of a sixteen-channel LED driver. A 193-bit register fills from a serial input one bit per shift strobe, moving toward its top bit, and the top bit is always on the serial output, so several devices can be chained. A latch strobe moves the lower 192 bits into a grayscale latch. The latch holds sixteen 12-bit brightness words for the PWM stage.

On that same strobe, once the grayscale copy is made, the register is overwritten with a packed image of the driver's fault flags. These are open LED, shorted LED, output leakage, pre-thermal warning, thermal error and reference short. The host then reads them out by shifting the next frame in. The capture happens only when the register's top bit is 0. A top bit of 1 marks a non-grayscale write, and the strobe then does nothing here. After a capture, further latch strobes are ignored until at least one new bit has been shifted in. The host can poll status without changing brightness by resending the grayscale data it last wrote.

All activity is on one system clock. Shift and latch events arrive as single-cycle strobes. The fault flags are plain parallel inputs and are sampled in the strobe cycle.

Top module: `serial_cfg_status`

## Requirements
- R1: After reset the register, the grayscale latch and the new-bit flag are all 0. The serial output reads 0 and a latch strobe is ignored until a bit has been shifted in.
- R2: A shift strobe moves the register one place toward bit 192 and puts the serial input in bit 0. The serial output always shows bit 192.
- R3: A latch strobe that acts (new-bit flag set and bit 192 equal to 0) copies register bits 191:0 into the grayscale latch on that edge.
- R4: The same acting strobe loads the flags into the register. Bit 113 is reference short, bit 114 pre-thermal warning and bit 115 thermal error. Leakage for outputs 0-7 goes to 127:120 and for outputs 8-15 to 139:132. Shorted LED goes to 151:144 and 163:156, and open LED to 175:168 and 187:180. Within each byte the lowest bit is the lowest-numbered output, and 1 means fault.
- R5: On a status load, bits 112:0, 119:116, 131:128, 143:140, 155:152, 167:164, 179:176, 191:188 and bit 192 all load as 0.
- R6: A latch strobe while bit 192 is 1 leaves both the grayscale latch and the register unchanged.
- R7: After a status load, latch strobes change nothing until a shift strobe has occurred. Resending the same grayscale data then returns fresh status with the latch unchanged.
- R8: When a shift and an acting latch strobe fall in the same cycle, the latch action wins and the shifted bit is dropped. If the latch does not act, the shift proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_stb | input | 1 | Single-cycle shift strobe |
| sin | input | 1 | Serial data in |
| lat_stb | input | 1 | Single-cycle latch strobe |
| open_flt | input | 16 | Open-LED flag per output |
| short_flt | input | 16 | Shorted-LED flag per output |
| leak_flt | input | 16 | Output leakage flag per output |
| pre_therm | input | 1 | Pre-thermal warning |
| therm_err | input | 1 | Thermal error |
| iref_short | input | 1 | Reference-resistor short |
| sout | output | 1 | Serial data out (register bit 192) |
| gs_q | output | 192 | Grayscale latch contents |

## Verification
The bench builds the block with its default 16 channels of 12 bits each. This gives the exact 193-bit frame, so every status position and reserved gap is read back through the serial output against a layout written independently as a field concatenation. Random frames with a random top bit and random flag patterns reach both the acting and the blocked strobe paths. Directed sequences cover strobes right after reset, a repeated strobe with no new bit, a resend of identical data, and a shift and latch in the same cycle.

// File: rtl/scsr_pkg.sv
package scsr_pkg;

  localparam int CH_NUM  = 16;
  localparam int GS_BITS = 12;
  localparam int GS_W    = CH_NUM * GS_BITS;
  localparam int SR_W    = GS_W + 1;
  localparam int GRP     = 8;

  // status positions inside the register
  localparam int POS_ISF = 113;
  localparam int POS_PTW = 114;
  localparam int POS_TEF = 115;
  // base of each 8-bit flag group; groups are 12 bits apart
  localparam int LEAK_LO  = 120;
  localparam int LEAK_HI  = 132;
  localparam int SHORT_LO = 144;
  localparam int SHORT_HI = 156;
  localparam int OPEN_LO  = 168;
  localparam int OPEN_HI  = 180;

  typedef struct packed {
    logic [CH_NUM-1:0] open_f;
    logic [CH_NUM-1:0] short_f;
    logic [CH_NUM-1:0] leak_f;
    logic              ptw;
    logic              tef;
    logic              isf;
  } flags_t;

  // Places one 16-bit flag set into two 8-bit groups.
  function automatic logic [SR_W-1:0] place_pair(
    input logic [CH_NUM-1:0] f, input int lo_base, input int hi_base);
    logic [SR_W-1:0] v;
    v = '0;
    for (int i = 0; i < GRP; i++) begin
      v[lo_base + i] = f[i];
      v[hi_base + i] = f[GRP + i];
    end
    return v;
  endfunction

  // Full status image; reserved positions and the top bit are 0.
  function automatic logic [SR_W-1:0] pack_status(input flags_t s);
    logic [SR_W-1:0] v;
    v = place_pair(s.leak_f, LEAK_LO, LEAK_HI)
      | place_pair(s.short_f, SHORT_LO, SHORT_HI)
      | place_pair(s.open_f, OPEN_LO, OPEN_HI);
    v[POS_ISF] = s.isf;
    v[POS_PTW] = s.ptw;
    v[POS_TEF] = s.tef;
    return v;
  endfunction

endpackage

// File: rtl/scsr_status_pack.sv
module scsr_status_pack
  import scsr_pkg::*;
(
  input  flags_t          flags,
  output logic [SR_W-1:0] image
);

  always_comb begin
    image = pack_status(flags);
  end

endmodule

// File: rtl/scsr_ctrl.sv
module scsr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_stb,
  input  logic lat_stb,
  input  logic msb,
  output logic shift_en,
  output logic sid_load,
  output logic fresh_bit
);

  logic fresh_q;

  // a latch acts only with a new bit seen and a clear top bit
  assign sid_load  = lat_stb & fresh_q & ~msb;
  // an acting latch takes the cycle; a coincident shift is dropped
  assign shift_en  = sclk_stb & ~sid_load;
  assign fresh_bit = fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fresh_q <= 1'b0;
    else if (sid_load) fresh_q <= 1'b0;
    else if (shift_en) fresh_q <= 1'b1;
  end

endmodule

// File: rtl/scsr_shift.sv
module scsr_shift #(
  parameter int WIDTH = 193
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sin,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] sr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (load_en)  sr_q <= load_val;
    else if (shift_en) sr_q <= {sr_q[WIDTH-2:0], sin};
  end

endmodule

// File: rtl/scsr_gs_latch.sv
module scsr_gs_latch #(
  parameter int WIDTH = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/serial_cfg_status.sv
module serial_cfg_status
  import scsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_stb,
  input  logic              sin,
  input  logic              lat_stb,
  input  logic [CH_NUM-1:0] open_flt,
  input  logic [CH_NUM-1:0] short_flt,
  input  logic [CH_NUM-1:0] leak_flt,
  input  logic              pre_therm,
  input  logic              therm_err,
  input  logic              iref_short,
  output logic              sout,
  output logic [GS_W-1:0]   gs_q
);

  // named internal events for the checker
  logic            shift_en;
  logic            sid_load;
  logic            fresh_bit;
  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] status_img;
  flags_t          flags;

  assign flags = '{open_f: open_flt, short_f: short_flt, leak_f: leak_flt,
                   ptw: pre_therm, tef: therm_err, isf: iref_short};

  scsr_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_stb  (sclk_stb),
    .lat_stb   (lat_stb),
    .msb       (sr_q[SR_W-1]),
    .shift_en  (shift_en),
    .sid_load  (sid_load),
    .fresh_bit (fresh_bit)
  );

  scsr_status_pack i_pack (
    .flags (flags),
    .image (status_img)
  );

  scsr_shift #(.WIDTH(SR_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .sin      (sin),
    .load_en  (sid_load),
    .load_val (status_img),
    .sr_q     (sr_q)
  );

  // grayscale copy takes the pre-load register contents on the same edge
  scsr_gs_latch #(.WIDTH(GS_W)) i_gs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sid_load),
    .d     (sr_q[GS_W-1:0]),
    .q     (gs_q)
  );

  assign sout = sr_q[SR_W-1];

endmodule

// File: rtl/scsr_chk.sv
module scsr_chk
  import scsr_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sclk_stb,
  input logic            lat_stb,
  input logic            sin,
  input logic            sout,
  input logic            iref_short,
  input logic            shift_en,
  input logic            sid_load,
  input logic            fresh_bit,
  input logic [SR_W-1:0] sr_q,
  input logic [GS_W-1:0] gs_q
);

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr_q[0] == $past(sin)) && (sr_q[SR_W-1:1] == $past(sr_q[SR_W-2:0])));

  // R3
  gs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sid_load |=> gs_q == $past(sr_q[GS_W-1:0]));

  // R4
  isf_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sid_load |=> sr_q[POS_ISF] == $past(iref_short));

  // R5
  top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sid_load |=> !sout);

  // R6
  msb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_stb && sr_q[SR_W-1] && !sclk_stb) |=> $stable(gs_q) && $stable(sr_q));

  // R7
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_stb && !fresh_bit && !sclk_stb) |=> $stable(gs_q) && $stable(sr_q));

  // R8
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_stb && sclk_stb && fresh_bit && !sr_q[SR_W-1]) |=> !fresh_bit && !sout);

endmodule

bind serial_cfg_status scsr_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_stb   (sclk_stb),
  .lat_stb    (lat_stb),
  .sin        (sin),
  .sout       (sout),
  .iref_short (iref_short),
  .shift_en   (shift_en),
  .sid_load   (sid_load),
  .fresh_bit  (fresh_bit),
  .sr_q       (sr_q),
  .gs_q       (gs_q)
);

// File: tb/test_serial_cfg_status.sv
`timescale 1ns/1ps
module test_serial_cfg_status;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk_stb = 1'b0;
  logic         sin = 1'b0;
  logic         lat_stb = 1'b0;
  logic [15:0]  open_flt = '0;
  logic [15:0]  short_flt = '0;
  logic [15:0]  leak_flt = '0;
  logic         pre_therm = 1'b0;
  logic         therm_err = 1'b0;
  logic         iref_short = 1'b0;
  logic         sout;
  logic [191:0] gs_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model
  logic [192:0] m_sr = '0;
  logic [191:0] m_gs = '0;
  bit           m_fresh = 0;

  always #2.5 clk = ~clk;

  serial_cfg_status i_serial_cfg_status (
    .clk(clk), .rst_n(rst_n), .sclk_stb(sclk_stb), .sin(sin), .lat_stb(lat_stb),
    .open_flt(open_flt), .short_flt(short_flt), .leak_flt(leak_flt),
    .pre_therm(pre_therm), .therm_err(therm_err), .iref_short(iref_short),
    .sout(sout), .gs_q(gs_q)
  );

  // status image written MSB-first as fields (R4, R5)
  function automatic logic [192:0] exp_image();
    return {1'b0,
            4'h0, open_flt[15:8],  4'h0, open_flt[7:0],
            4'h0, short_flt[15:8], 4'h0, short_flt[7:0],
            4'h0, leak_flt[15:8],  4'h0, leak_flt[7:0],
            4'h0, therm_err, pre_therm, iref_short, 113'd0};
  endfunction

  function automatic logic [192:0] rnd_frame(input bit top);
    logic [192:0] v;
    for (int k = 0; k < 7; k++) v[k*32 +: 32] = $urandom();
    v[192] = top;
    return v;
  endfunction

  task automatic rnd_flags();
    open_flt   = 16'($urandom());
    short_flt  = 16'($urandom());
    leak_flt   = 16'($urandom());
    pre_therm  = 1'($urandom());
    therm_err  = 1'($urandom());
    iref_short = 1'($urandom());
  endtask

  task automatic check(input bit ok, input string req, input logic [192:0] act,
                       input logic [192:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one strobe cycle, entered and left at a negedge
  task automatic pulse(input bit s, input bit l, input bit b);
    bit act;
    sclk_stb = s; lat_stb = l; sin = b;
    act = l && m_fresh && !m_sr[192];
    if (act) begin
      m_gs = m_sr[191:0];
      m_sr = exp_image();
      m_fresh = 0;
    end else if (s) begin
      m_sr = {m_sr[191:0], b};
      m_fresh = 1;
    end
    @(negedge clk);
    sclk_stb = 0; lat_stb = 0;
  endtask

  // shifts a frame in while collecting what comes out
  task automatic shift_frame(input logic [192:0] v, input string req);
    logic [192:0] got, exp;
    for (int i = 192; i >= 0; i--) begin
      got[i] = sout;
      exp[i] = m_sr[192];
      pulse(1, 0, v[i]);
    end
    check(got === exp, req, got, exp);
  endtask

  task automatic chk_gs(input logic [191:0] e, input string req);
    check(gs_q === e, req, {1'b0, gs_q}, {1'b0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [192:0] fa, fb;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(sout === 1'b0, "R1 sout", {192'd0, sout}, '0);
    chk_gs('0, "R1 gs");

    // R1/R7: strobe before any shift is ignored
    rnd_flags();
    pulse(0, 1, 0);
    chk_gs('0, "R7 after reset");
    fa = rnd_frame(0);
    shift_frame(fa, "R1 R2 no load after reset");

    // R3/R4/R5: random frames, random top bit, random flags
    for (int t = 0; t < 14; t++) begin
      rnd_flags();
      pulse(0, 1, 0);
      chk_gs(m_gs, "R3 R6 gs after strobe");
      check(sout === m_sr[192], "R5 top bit", {192'd0, sout}, {192'd0, m_sr[192]});
      fb = rnd_frame((t % 4) == 3);
      shift_frame(fb, "R2 R4 R5 R6 readback");
    end

    // R7: resend same data, fresh status, latch unchanged
    fa = rnd_frame(0);
    shift_frame(fa, "R2");
    pulse(0, 1, 0);
    chk_gs(fa[191:0], "R3 first write");
    rnd_flags();
    shift_frame(fa, "R4 first status");
    rnd_flags();
    fb = exp_image();
    pulse(0, 1, 0);
    chk_gs(fa[191:0], "R7 same data keeps latch");
    // R7: second strobe without a new bit does nothing
    rnd_flags();
    open_flt = ~open_flt;
    pulse(0, 1, 0);
    chk_gs(fa[191:0], "R7 locked strobe");
    check(m_sr === fb, "R7 model", m_sr, fb);
    shift_frame(rnd_frame(1), "R7 status not refreshed");

    // R6: top bit set blocks everything
    m_fresh = m_fresh;
    fa = rnd_frame(1);
    shift_frame(fa, "R2");
    rnd_flags();
    fb = {1'b0, gs_q};
    pulse(0, 1, 0);
    chk_gs(fb[191:0], "R6 latch kept");
    shift_frame(rnd_frame(0), "R6 frame kept");

    // R8: shift and acting strobe together
    rnd_flags();
    fa = m_sr;
    pulse(1, 1, 1);
    chk_gs(fa[191:0], "R8 latch took pre-shift data");
    shift_frame(rnd_frame(0), "R8 shift dropped");
    // R8: non-acting strobe (locked) lets the shift through
    pulse(0, 1, 0);
    rnd_flags();
    pulse(1, 1, 1);
    shift_frame(rnd_frame(0), "R8 shift kept");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule